// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block sits beside the sequencer of an asynchronous bus master. It watches three termination inputs: a data acknowledge, a bus-error input and a halt input. From them it decides how each bus cycle ends. A cycle can end normally, in a bus error, in a retry, or by stopping the master under halt. The block then tells the sequencer when to abort the cycle and when to float the address and data buses. It also says when to re-run the last cycle with its stored function code, address and write data, and when to raise a bus-error exception request.

At the start of every cycle the controller stores the function code, address, direction, write data and read-modify-write flag. A retry replays these stored values. Read-modify-write cycles are never retried, and a bus error that arrives within one clock after the acknowledge is still treated as an error. The cycle's last clock is a one-clock window after the acknowledge. A small protocol check flags a halt release that does not trail the bus-error release by at least one clock.

Top module: `buscyc_term_ctrl`

## Requirements
- R1: After a synchronous active-low reset, abort, abort_long, float_bus, retry_start, done, exc_req, halted and proto_err are all low.
- R2: Suppose acknowledge is sampled high with bus-error low in a cycle. If the following clock then samples bus-error low, done pulses for one clock on that second edge, and no abort occurs.
- R3: Bus-error sampled high with halt low causes a one-clock abort pulse, and float_bus rises on the same edge. float_bus stays high while bus-error stays high. On the edge that samples bus-error low, float_bus falls and exc_req pulses for one clock. exc_off always carries 8'h08, which is vector entry 2 times four.
- R4: A late error is handled as a bus error, with abort and then exc_req, and no done pulse. A late error is bus-error sampled high, with halt low, on the clock right after the edge that sampled acknowledge.
- R5: Bus-error and halt sampled high together in a non-read-modify-write cycle cause an abort, and float_bus then stays high. Once bus-error has been sampled low and halt is later sampled low, retry_start pulses for one clock and float_bus falls. The controller then runs the cycle again.
- R6: In a cycle marked read-modify-write, bus-error together with halt takes the bus-error path: abort, then exc_req. retry_start never pulses.
- R7: abort_long is high with the abort pulse only when the aborted cycle is the write half of a read-modify-write cycle (cyc_rmw=1 and cyc_we=1). It is low with every other abort.
- R8: Halt alone does not disturb a running cycle. When the cycle ends with done, halted rises on that same edge. halted stays high while halt stays high, and falls on the edge that samples halt low.
- R9: During a retry, if bus-error and halt are sampled low on the same edge, proto_err pulses for one clock together with retry_start.
- R10: cyc_start is taken only while the controller is idle, and the rp_fc, rp_addr, rp_we, rp_wdata and rp_rmw outputs replay the values captured then. A cyc_start during a running cycle leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | Sequencer begins a new bus cycle |
| cyc_fc | input | FC_W | Function code of the new cycle |
| cyc_addr | input | ADDR_W | Address of the new cycle |
| cyc_we | input | 1 | New cycle is a write |
| cyc_wdata | input | DATA_W | Write data of the new cycle |
| cyc_rmw | input | 1 | New cycle belongs to a read-modify-write sequence |
| dtack | input | 1 | Data acknowledge, active high |
| berr | input | 1 | Bus error, active high |
| halt | input | 1 | Halt, active high |
| abort | output | 1 | One-clock pulse: terminate the current cycle |
| abort_long | output | 1 | With abort: end at the late write-half phase |
| float_bus | output | 1 | Hold address and data buses at high impedance |
| retry_start | output | 1 | One-clock pulse: re-run the stored cycle |
| rp_fc | output | FC_W | Stored function code |
| rp_addr | output | ADDR_W | Stored address |
| rp_we | output | 1 | Stored direction |
| rp_wdata | output | DATA_W | Stored write data |
| rp_rmw | output | 1 | Stored read-modify-write flag |
| done | output | 1 | One-clock pulse: cycle ended normally |
| exc_req | output | 1 | One-clock pulse: bus-error exception request |
| exc_off | output | 8 | Byte offset of the bus-error vector |
| halted | output | 1 | Master is stopped under halt |
| proto_err | output | 1 | Halt released too early in a retry |

## Verification
The main function is tried with several termination patterns. Acknowledge alone shows that a normal end needs one clean clock after the acknowledge. Bus-error alone and bus-error right after acknowledge show that both early and late errors reach the exception request. Bus-error together with halt is applied to plain and read-modify-write cycles. This separates a retry from a forced error and shows that the replayed values survive a stray start. Halt alone, and halt released together with bus-error, show the stop state and the protocol flag, and show that neither is mistaken for an error.

// File: rtl/bct_pkg.sv
// Package: shared state type and derived constants for the bus cycle
// termination controller. Assumes 8-bit vector offsets.
package bct_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_TAIL   = 3'd2,
        ST_ERRW   = 3'd3,
        ST_RTY_B  = 3'd4,
        ST_RTY_H  = 3'd5,
        ST_STOP   = 3'd6
    } bct_state_e;

    // Byte offset of a vector table entry (four bytes per entry).
    function automatic logic [7:0] vec_offset(input int unsigned idx);
        return 8'(idx * 4);
    endfunction
endpackage

// File: rtl/bct_decode.sv
// Module: bct_decode
// Purely combinational classification of the termination inputs.
// Assumes the inputs are already synchronous to clk and active high.
module bct_decode (
    input  logic berr,
    input  logic halt,
    input  logic dtack,
    input  logic rmw,
    output logic is_err,
    output logic is_retry,
    output logic is_ack
);
    // Classify: error wins over retry for read-modify-write cycles.
    always_comb begin
        is_err   = berr && (!halt || rmw);
        is_retry = berr && halt && !rmw;
        is_ack   = dtack && !berr;
    end
endmodule

// File: rtl/bct_latch.sv
// Module: bct_latch
// Stores the attributes of a bus cycle when it is accepted so a retry
// can replay them. Assumes cap_en is asserted only for accepted starts.
module bct_latch #(
    parameter int FC_W   = 3,
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [FC_W-1:0]   in_fc,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_we,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              in_rmw,
    output logic [FC_W-1:0]   q_fc,
    output logic [ADDR_W-1:0] q_addr,
    output logic              q_we,
    output logic [DATA_W-1:0] q_wdata,
    output logic              q_rmw
);
    // Capture cycle attributes on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_fc    <= '0;
            q_addr  <= '0;
            q_we    <= 1'b0;
            q_wdata <= '0;
            q_rmw   <= 1'b0;
        end else if (cap_en) begin
            q_fc    <= in_fc;
            q_addr  <= in_addr;
            q_we    <= in_we;
            q_wdata <= in_wdata;
            q_rmw   <= in_rmw;
        end
    end
endmodule

// File: rtl/bct_fsm.sv
// Module: bct_fsm
// Sequences a cycle from start to its end: normal, error, retry or stop.
// Pulse outputs are registered and last one clock. Assumes decode inputs
// come from bct_decode for the stored cycle.
module bct_fsm
    import bct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic berr,
    input  logic halt,
    input  logic is_err,
    input  logic is_retry,
    input  logic is_ack,
    input  logic long_wr,
    output logic cap_en,
    output logic abort,
    output logic abort_long,
    output logic retry_start,
    output logic done,
    output logic exc_req,
    output logic proto_err,
    output logic float_bus,
    output logic halted
);
    bct_state_e st;

    // Accept a start only when idle.
    assign cap_en    = cyc_start && (st == ST_IDLE);
    // Bus float covers the error wait and both retry holds.
    assign float_bus = (st == ST_ERRW) || (st == ST_RTY_B) || (st == ST_RTY_H);
    assign halted    = (st == ST_STOP);

    // State transitions and one-clock pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            abort       <= 1'b0;
            abort_long  <= 1'b0;
            retry_start <= 1'b0;
            done        <= 1'b0;
            exc_req     <= 1'b0;
            proto_err   <= 1'b0;
        end else begin
            abort       <= 1'b0;
            abort_long  <= 1'b0;
            retry_start <= 1'b0;
            done        <= 1'b0;
            exc_req     <= 1'b0;
            proto_err   <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cyc_start) st <= ST_RUN;
                end
                ST_RUN, ST_TAIL: begin
                    if (is_err) begin
                        st         <= ST_ERRW;
                        abort      <= 1'b1;
                        abort_long <= long_wr;
                    end else if (is_retry) begin
                        st    <= ST_RTY_B;
                        abort <= 1'b1;
                    end else if (st == ST_RUN) begin
                        if (is_ack) st <= ST_TAIL;
                    end else begin
                        done <= 1'b1;
                        st   <= halt ? ST_STOP : ST_IDLE;
                    end
                end
                ST_ERRW: begin
                    if (!berr) begin
                        exc_req <= 1'b1;
                        st      <= ST_IDLE;
                    end
                end
                ST_RTY_B: begin
                    if (!berr) begin
                        if (!halt) begin
                            proto_err   <= 1'b1;
                            retry_start <= 1'b1;
                            st          <= ST_RUN;
                        end else begin
                            st <= ST_RTY_H;
                        end
                    end
                end
                ST_RTY_H: begin
                    if (!halt) begin
                        retry_start <= 1'b1;
                        st          <= ST_RUN;
                    end
                end
                ST_STOP: begin
                    if (!halt) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/buscyc_term_ctrl.sv
// Module: buscyc_term_ctrl (top)
// Decides how each asynchronous bus cycle terminates and drives abort,
// float, retry and exception signals for the cycle sequencer. Assumes
// dtack, berr and halt are synchronised, active high, before this block.
module buscyc_term_ctrl #(
    parameter int FC_W    = 3,
    parameter int ADDR_W  = 23,
    parameter int DATA_W  = 16,
    parameter int VEC_IDX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [FC_W-1:0]   cyc_fc,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_we,
    input  logic [DATA_W-1:0] cyc_wdata,
    input  logic              cyc_rmw,
    input  logic              dtack,
    input  logic              berr,
    input  logic              halt,
    output logic              abort,
    output logic              abort_long,
    output logic              float_bus,
    output logic              retry_start,
    output logic [FC_W-1:0]   rp_fc,
    output logic [ADDR_W-1:0] rp_addr,
    output logic              rp_we,
    output logic [DATA_W-1:0] rp_wdata,
    output logic              rp_rmw,
    output logic              done,
    output logic              exc_req,
    output logic [7:0]        exc_off,
    output logic              halted,
    output logic              proto_err
);
    import bct_pkg::*;

    localparam logic [7:0] EXC_OFF = vec_offset(VEC_IDX);

    logic is_err, is_retry, is_ack, cap_en, long_wr;

    assign exc_off = EXC_OFF;
    assign long_wr = rp_rmw && rp_we;

    bct_latch #(.FC_W(FC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
        .in_fc(cyc_fc), .in_addr(cyc_addr), .in_we(cyc_we),
        .in_wdata(cyc_wdata), .in_rmw(cyc_rmw),
        .q_fc(rp_fc), .q_addr(rp_addr), .q_we(rp_we),
        .q_wdata(rp_wdata), .q_rmw(rp_rmw)
    );

    bct_decode u_dec (
        .berr(berr), .halt(halt), .dtack(dtack), .rmw(rp_rmw),
        .is_err(is_err), .is_retry(is_retry), .is_ack(is_ack)
    );

    bct_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
        .berr(berr), .halt(halt),
        .is_err(is_err), .is_retry(is_retry), .is_ack(is_ack),
        .long_wr(long_wr), .cap_en(cap_en),
        .abort(abort), .abort_long(abort_long), .retry_start(retry_start),
        .done(done), .exc_req(exc_req), .proto_err(proto_err),
        .float_bus(float_bus), .halted(halted)
    );

    // Pulses are mutually exclusive (R2, R3, R5).
    a_r2_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({abort, retry_start, done, exc_req}));
    // An abort always floats the buses (R3).
    a_r3_abort_floats: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> float_bus);
    // Exception request follows a floated period (R3).
    a_r3_exc_after_float: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> ($past(float_bus) && !float_bus));
    // No retry of read-modify-write cycles (R6).
    a_r6_no_rmw_retry: assert property (@(posedge clk) disable iff (!rst_n)
        retry_start |-> !rp_rmw);
    // Long abort only accompanies an abort (R7).
    a_r7_long_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort_long |-> abort);
    // Stopped master does not float or abort (R8).
    a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!float_bus && !abort));
    // Protocol flag only with a retry start (R9).
    a_r9_proto_with_retry: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> retry_start);
endmodule

// File: tb/buscyc_term_ctrl_test.sv
module buscyc_term_ctrl_test;
    localparam int FC_W = 3, ADDR_W = 23, DATA_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cyc_start = 1'b0, cyc_we = 1'b0, cyc_rmw = 1'b0;
    logic [FC_W-1:0] cyc_fc = '0;
    logic [ADDR_W-1:0] cyc_addr = '0;
    logic [DATA_W-1:0] cyc_wdata = '0;
    logic dtack = 1'b0, berr = 1'b0, halt = 1'b0;
    logic abort, abort_long, float_bus, retry_start, rp_we, rp_rmw;
    logic done, exc_req, halted, proto_err;
    logic [FC_W-1:0] rp_fc;
    logic [ADDR_W-1:0] rp_addr;
    logic [DATA_W-1:0] rp_wdata;
    logic [7:0] exc_off;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    buscyc_term_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_fc(cyc_fc),
        .cyc_addr(cyc_addr), .cyc_we(cyc_we), .cyc_wdata(cyc_wdata),
        .cyc_rmw(cyc_rmw), .dtack(dtack), .berr(berr), .halt(halt),
        .abort(abort), .abort_long(abort_long), .float_bus(float_bus),
        .retry_start(retry_start), .rp_fc(rp_fc), .rp_addr(rp_addr),
        .rp_we(rp_we), .rp_wdata(rp_wdata), .rp_rmw(rp_rmw), .done(done),
        .exc_req(exc_req), .exc_off(exc_off), .halted(halted),
        .proto_err(proto_err)
    );

    task automatic chk(input longint act, input longint exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic start_cycle(input logic [2:0] fc, input logic [22:0] a,
                               input logic we, input logic [15:0] d,
                               input logic rmw);
        cyc_start = 1'b1; cyc_fc = fc; cyc_addr = a; cyc_we = we;
        cyc_wdata = d; cyc_rmw = rmw;
        tick();
        cyc_start = 1'b0;
    endtask

    task automatic t_reset();
        chk(abort, 0, "R1 abort");
        chk(float_bus, 0, "R1 float_bus");
        chk(retry_start, 0, "R1 retry_start");
        chk(done, 0, "R1 done");
        chk(exc_req, 0, "R1 exc_req");
        chk(halted, 0, "R1 halted");
        chk(proto_err, 0, "R1 proto_err");
        chk(abort_long, 0, "R1 abort_long");
    endtask

    task automatic t_normal();
        start_cycle(3'd1, 23'h1234, 1'b0, 16'h0, 1'b0);
        dtack = 1'b1; tick(); dtack = 1'b0;
        chk(done, 0, "R2 done not before tail");
        tick();
        chk(done, 1, "R2 done pulse");
        chk(abort, 0, "R2 no abort");
        tick();
        chk(done, 0, "R2 done one clock");
    endtask

    task automatic t_error();
        start_cycle(3'd2, 23'h0100, 1'b0, 16'h0, 1'b0);
        berr = 1'b1; tick();
        chk(abort, 1, "R3 abort");
        chk(float_bus, 1, "R3 float on abort");
        chk(abort_long, 0, "R7 short abort read");
        tick(); tick();
        chk(float_bus, 1, "R3 float held with berr");
        chk(exc_req, 0, "R3 no exc while berr");
        berr = 1'b0; tick();
        chk(exc_req, 1, "R3 exc_req");
        chk(float_bus, 0, "R3 float released");
        chk(exc_off, 8'h08, "R3 exc_off");
        tick();
        chk(exc_req, 0, "R3 exc one clock");
    endtask

    task automatic t_late();
        start_cycle(3'd1, 23'h0200, 1'b0, 16'h0, 1'b0);
        dtack = 1'b1; tick();
        berr = 1'b1; tick();
        chk(abort, 1, "R4 late abort");
        chk(done, 0, "R4 no done");
        dtack = 1'b0; berr = 1'b0; tick();
        chk(exc_req, 1, "R4 exc_req");
        chk(done, 0, "R4 still no done");
    endtask

    task automatic t_retry();
        start_cycle(3'd5, 23'h3A5A5, 1'b1, 16'hBEEF, 1'b0);
        // stray start with other values while running (R10)
        cyc_start = 1'b1; cyc_addr = 23'h00077; cyc_wdata = 16'h1111; cyc_fc = 3'd0;
        berr = 1'b1; halt = 1'b1; tick();
        cyc_start = 1'b0;
        chk(abort, 1, "R5 abort");
        chk(float_bus, 1, "R5 float");
        berr = 1'b0; tick();
        chk(float_bus, 1, "R5 float while halt");
        chk(retry_start, 0, "R5 no early retry");
        halt = 1'b0; tick();
        chk(retry_start, 1, "R5 retry_start");
        chk(float_bus, 0, "R5 float released");
        chk(proto_err, 0, "R9 no flag on proper release");
        chk(rp_addr, 23'h3A5A5, "R10 replay addr");
        chk(rp_wdata, 16'hBEEF, "R10 replay data");
        chk(rp_fc, 3'd5, "R10 replay fc");
        chk(rp_we, 1, "R10 replay we");
        dtack = 1'b1; tick(); dtack = 1'b0; tick();
        chk(done, 1, "R5 rerun completes");
    endtask

    task automatic t_proto();
        start_cycle(3'd1, 23'h0400, 1'b0, 16'h0, 1'b0);
        berr = 1'b1; halt = 1'b1; tick();
        chk(abort, 1, "R9 abort");
        berr = 1'b0; halt = 1'b0; tick();
        chk(proto_err, 1, "R9 proto_err");
        chk(retry_start, 1, "R9 retry with flag");
        tick();
        chk(proto_err, 0, "R9 flag one clock");
        dtack = 1'b1; tick(); dtack = 1'b0; tick();
        chk(done, 1, "R9 rerun completes");
    endtask

    task automatic t_rmw_read();
        start_cycle(3'd1, 23'h0500, 1'b0, 16'h0, 1'b1);
        berr = 1'b1; halt = 1'b1; tick();
        chk(abort, 1, "R6 abort");
        chk(abort_long, 0, "R7 rmw read half short");
        berr = 1'b0; halt = 1'b0; tick();
        chk(exc_req, 1, "R6 exc_req");
        chk(retry_start, 0, "R6 no retry");
        chk(proto_err, 0, "R6 no proto flag");
    endtask

    task automatic t_rmw_write();
        start_cycle(3'd1, 23'h0600, 1'b1, 16'h5555, 1'b1);
        berr = 1'b1; tick();
        chk(abort, 1, "R7 abort");
        chk(abort_long, 1, "R7 abort_long write half");
        tick();
        chk(abort_long, 0, "R7 abort_long one clock");
        berr = 1'b0; tick();
        chk(exc_req, 1, "R7 exc_req");
    endtask

    task automatic t_halt();
        start_cycle(3'd1, 23'h0700, 1'b0, 16'h0, 1'b0);
        halt = 1'b1; tick();
        chk(abort, 0, "R8 halt no abort");
        chk(halted, 0, "R8 not stopped mid cycle");
        dtack = 1'b1; tick(); dtack = 1'b0; tick();
        chk(done, 1, "R8 cycle finishes");
        chk(halted, 1, "R8 halted");
        tick(); tick();
        chk(halted, 1, "R8 stays halted");
        halt = 1'b0; tick();
        chk(halted, 0, "R8 released");
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1; tick();
        t_normal();
        t_error();
        t_late();
        t_retry();
        t_proto();
        t_rmw_read();
        t_rmw_write();
        t_halt();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule